// File: doc/BRIEF.md
# Programmable Time-Bin Hit Flagger

The block takes one channel's live sample stream, delivered as one 10-bit word per word clock, with bit 9 the earliest sample of the word and bit 0 the latest. A one-cycle bunch-start pulse, aligned to the calibrated t0 reference, marks the first word of each bunch interval. Within the interval, the block counts words and looks for runs of four consecutive 1 samples. A run may lie inside one word or cross from one word into the next. When a run completes, the block finds which of six contiguous time windows holds the current word index and marks that window.

The window edges come from six 6-bit boundary fields, expressed in word clocks. The first window starts at word 0. Each later window starts where the one before it ends. When the next bunch-start pulse arrives, the window marks gathered during the interval just ended are moved into six registered flags. From the second clock of the new interval, these flags stay steady on the output, and a one-cycle strobe marks the update. A mode input can replace the six-window result with two legacy bits built from the first three windows.

Top module: `tbf_hit_flagger`

## Requirements
- R1: A word that contains four consecutive 1 bits at any position is a hit for that word's index.
- R2: A run of four 1 bits that starts in the last bits of one word (bits 2:0, with bit 0 the latest sample) and continues into the first bits of the next word (from bit 9 down) is a hit for the later word's index.
- R3: Runs of three or fewer 1 bits, whether inside a word or across a word boundary, set no flag.
- R4: The word presented with bunch_start_i has index 0, and each later word has an index one higher. Field k of bounds_i sits at bits 6k+5:6k. Window k covers indices from field k-1 (0 for k=0) up to, but not including, field k. A hit marks the window that holds its index. A zero-width window is never marked.
- R5: The index stops at 63. A hit at an index at or beyond field 5 marks no window. A hit before the first bunch-start pulse after reset also marks no window.
- R6: Marks accumulate through an interval, so hits in several windows set several flags. Marking restarts with the bunch-start word.
- R7: On a bunch-start cycle, flags_o takes the marks of the interval that just ended. The new value is visible from the next clock and holds until the next bunch-start cycle.
- R8: strobe_o is high for exactly the one cycle that follows each bunch-start cycle.
- R9: When legacy_mode_i is high in the bunch-start cycle, flags_o[0] = window0 OR window1, flags_o[1] = window1 OR window2, and flags_o[5:2] = 0.
- R10: Reset clears the flags, the strobe and the carried sample bits, and leaves the index parked at 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 10 | Sample word, bit 9 earliest |
| bunch_start_i | input | 1 | t0-aligned start of bunch interval; this word has index 0 |
| legacy_mode_i | input | 1 | 1 selects the two-bit legacy result |
| bounds_i | input | 36 | Six 6-bit window end boundaries, field k at bits 6k+5:6k |
| flags_o | output | 6 | Window flags of the previous interval |
| strobe_o | output | 1 | One-cycle pulse when flags_o is updated |

## Verification
The assertions check, on every cycle, the following properties:
- the strobe follows the bunch-start pulse and lasts one cycle;
- the flags hold steady between bunch starts;
- the legacy upper flags are zero;
- the per-interval marks never lose a bit;
- a parked index selects no window;
- an all-ones word always counts as a hit.

Only the bench scenarios can show the rest:
- which window receives a hit at and near each boundary;
- detection of runs that cross a word edge;
- rejection of three-bit runs;
- correct flag values after each interval under random boundaries and random mode changes.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
    parameter int unsigned WORD_W   = 10;
    parameter int unsigned RUN_LEN  = 4;
    parameter int unsigned NUM_BINS = 6;
    parameter int unsigned IDX_W    = 6;

    typedef enum logic {
        MODE_SIX_BIN = 1'b0,
        MODE_LEGACY  = 1'b1
    } bin_mode_e;
endpackage

// File: rtl/tbf_run_detect.sv
module tbf_run_detect #(
    parameter int unsigned WORD_W  = tbf_pkg::WORD_W,
    parameter int unsigned RUN_LEN = tbf_pkg::RUN_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o
);
    localparam int unsigned TAIL_W = RUN_LEN - 1;
    localparam int unsigned EXT_W  = WORD_W + TAIL_W;

    typedef struct packed {
        logic [TAIL_W-1:0] tail;
    } det_state_t;

    det_state_t        st_d, st_q;
    logic [EXT_W-1:0]  ext;
    logic [WORD_W-1:0] win_full;

    // Carried latest samples followed by the new word, earliest at the top.
    assign ext = {st_q.tail, word_i};

    // Every window of RUN_LEN samples that ends inside the current word.
    for (genvar g = 0; g < WORD_W; g++) begin : g_win
        assign win_full[g] = &ext[g +: RUN_LEN];
    end

    assign hit_o = |win_full;

    always_comb begin
        st_d      = st_q;
        st_d.tail = word_i[TAIL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_full_word_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (&word_i) |-> hit_o);
endmodule

// File: rtl/tbf_bin_pick.sv
module tbf_bin_pick #(
    parameter int unsigned NUM_BINS = tbf_pkg::NUM_BINS,
    parameter int unsigned IDX_W    = tbf_pkg::IDX_W
) (
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [NUM_BINS*IDX_W-1:0] bounds_i,
    output logic [NUM_BINS-1:0]       sel_o
);
    logic [NUM_BINS-1:0] below;
    logic [NUM_BINS:0]   taken;

    assign taken[0] = 1'b0;

    // First window whose end lies beyond the index wins.
    for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
        assign below[g]   = idx_i < bounds_i[g*IDX_W +: IDX_W];
        assign sel_o[g]   = below[g] & ~taken[g];
        assign taken[g+1] = taken[g] | below[g];
    end
endmodule

// File: rtl/tbf_hit_flagger.sv
module tbf_hit_flagger #(
    parameter int unsigned WORD_W   = tbf_pkg::WORD_W,
    parameter int unsigned RUN_LEN  = tbf_pkg::RUN_LEN,
    parameter int unsigned NUM_BINS = tbf_pkg::NUM_BINS,
    parameter int unsigned IDX_W    = tbf_pkg::IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORD_W-1:0]         word_i,
    input  logic                      bunch_start_i,
    input  logic                      legacy_mode_i,
    input  logic [NUM_BINS*IDX_W-1:0] bounds_i,
    output logic [NUM_BINS-1:0]       flags_o,
    output logic                      strobe_o
);
    import tbf_pkg::*;

    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    typedef struct packed {
        logic [IDX_W-1:0]    idx;
        logic [NUM_BINS-1:0] acc;
        logic [NUM_BINS-1:0] flags;
        logic                strobe;
    } flag_state_t;

    flag_state_t         st_d, st_q;
    logic [IDX_W-1:0]    cur_idx;
    logic                hit;
    logic [NUM_BINS-1:0] sel;
    logic [NUM_BINS-1:0] contrib;
    logic [NUM_BINS-1:0] result;
    bin_mode_e           mode;

    tbf_run_detect #(.WORD_W(WORD_W), .RUN_LEN(RUN_LEN)) detect_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (word_i),
        .hit_o  (hit)
    );

    tbf_bin_pick #(.NUM_BINS(NUM_BINS), .IDX_W(IDX_W)) pick_i (
        .idx_i    (cur_idx),
        .bounds_i (bounds_i),
        .sel_o    (sel)
    );

    assign mode = bin_mode_e'(legacy_mode_i);

    always_comb begin
        st_d = st_q;

        // Index of the word presented this cycle.
        if (bunch_start_i) begin
            cur_idx = '0;
        end else if (st_q.idx == IDX_MAX) begin
            cur_idx = IDX_MAX;
        end else begin
            cur_idx = st_q.idx + 1'b1;
        end

        contrib = hit ? sel : '0;

        // Result of the closing interval, collapsed in legacy mode.
        result = st_q.acc;
        if (mode == MODE_LEGACY) begin
            result    = '0;
            result[0] = st_q.acc[0] | st_q.acc[1];
            result[1] = st_q.acc[1] | st_q.acc[2];
        end

        st_d.idx    = cur_idx;
        st_d.strobe = bunch_start_i;
        if (bunch_start_i) begin
            st_d.acc   = contrib;
            st_d.flags = result;
        end else begin
            st_d.acc   = st_q.acc | contrib;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.idx    <= IDX_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o  = st_q.flags;
    assign strobe_o = st_q.strobe;

    assert_strobe_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bunch_start_i |=> strobe_o);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bunch_start_i |=> !strobe_o);

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bunch_start_i |=> $stable(flags_o));

    assert_legacy_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bunch_start_i && legacy_mode_i) |=> (flags_o[NUM_BINS-1:2] == '0));

    assert_acc_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bunch_start_i |=> ((st_q.acc & $past(st_q.acc)) == $past(st_q.acc)));

    assert_parked_no_bin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_idx == IDX_MAX) |-> (sel == '0));
endmodule

// File: tb/tbf_hit_flagger_tb_top.sv
module tbf_hit_flagger_tb_top;
    localparam int WW = 10;
    localparam int NB = 6;
    localparam int IW = 6;
    localparam logic [WW-1:0] HITW = 10'b0001111000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] word_i = '0;
    logic          bunch_start_i = 1'b0;
    logic          legacy_mode_i = 1'b0;
    logic [NB*IW-1:0] bounds_i = '0;
    logic [NB-1:0] flags_o;
    logic          strobe_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [2:0]    m_tail = '0;
    int            m_idx = 63;
    logic [NB-1:0] m_acc = '0;
    logic [NB-1:0] m_flags = '0;
    logic          m_strobe = 1'b0;

    always #5 clk = ~clk;

    tbf_hit_flagger dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_i        (word_i),
        .bunch_start_i (bunch_start_i),
        .legacy_mode_i (legacy_mode_i),
        .bounds_i      (bounds_i),
        .flags_o       (flags_o),
        .strobe_o      (strobe_o)
    );

    function automatic logic f_hit(logic [2:0] tail, logic [WW-1:0] w);
        logic [WW+2:0] s;
        int run;
        logic h;
        s = {tail, w};
        run = 0;
        h = 1'b0;
        for (int i = WW + 2; i >= 0; i--) begin
            run = s[i] ? run + 1 : 0;
            if (run >= 4 && i < WW) h = 1'b1;
        end
        return h;
    endfunction

    function automatic logic [NB-1:0] f_bin(int idx, logic [NB*IW-1:0] b);
        int lo;
        int hi;
        lo = 0;
        for (int k = 0; k < NB; k++) begin
            hi = int'(b[k*IW +: IW]);
            if (idx >= lo && idx < hi) return NB'(1) << k;
            lo = hi;
        end
        return '0;
    endfunction

    function automatic logic [NB-1:0] f_map(logic [NB-1:0] a, logic leg);
        logic [NB-1:0] r;
        if (!leg) return a;
        r = '0;
        r[0] = a[0] | a[1];
        r[1] = a[1] | a[2];
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_bounds(input int b0, input int b1, input int b2,
                              input int b3, input int b4, input int b5);
        bounds_i = {IW'(b5), IW'(b4), IW'(b3), IW'(b2), IW'(b1), IW'(b0)};
    endtask

    // One word clock: drive, advance the model, compare after the edge.
    task automatic step(input logic [WW-1:0] w, input logic bs, input string tag);
        int cur;
        logic [NB-1:0] contrib;
        word_i = w;
        bunch_start_i = bs;
        cur = bs ? 0 : (m_idx == 63 ? 63 : m_idx + 1);
        contrib = f_hit(m_tail, w) ? f_bin(cur, bounds_i) : '0;
        if (bs) begin
            m_flags = f_map(m_acc, legacy_mode_i);
            m_acc = contrib;
        end else begin
            m_acc = m_acc | contrib;
        end
        m_strobe = bs;
        m_idx = cur;
        m_tail = w[2:0];
        @(posedge clk);
        #1;
        chk(flags_o == m_flags, tag, int'(flags_o), int'(m_flags));
        chk(strobe_o == m_strobe, tag, int'(strobe_o), int'(m_strobe));
    endtask

    task automatic run_interval(input int len, input int ha, input int hb);
        for (int i = 0; i < len; i++) begin
            step((i == ha || i == hb) ? HITW : '0, i == 0, "R4");
        end
    endtask

    task automatic close_check(input logic [NB-1:0] exp, input string tag);
        step('0, 1'b1, tag);
        chk(flags_o == exp, tag, int'(flags_o), int'(exp));
        chk(strobe_o == 1'b1, "R8", int'(strobe_o), 1);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        int len;
        int b[NB];
        int tmp;
        logic [WW-1:0] w;
        seed_dummy = $urandom(32'h5EED_0042);
        set_bounds(5, 10, 15, 20, 25, 30);
        repeat (3) @(posedge clk);
        #1;
        chk(flags_o == '0, "R10", int'(flags_o), 0);
        chk(strobe_o == 1'b0, "R10", int'(strobe_o), 0);
        rst_n = 1'b1;

        // R5: hits before any bunch start mark nothing.
        for (int i = 0; i < 8; i++) step('1, 1'b0, "R5");
        close_check('0, "R5");

        // R1: in-word run at index 7 lands in window 1.
        run_interval(12, 7, -1);
        close_check(6'b000010, "R1");

        // R4 boundaries: index 4 in window 0, index 5 in window 1.
        run_interval(8, 4, -1);
        close_check(6'b000001, "R4");
        run_interval(8, 5, -1);
        close_check(6'b000010, "R4");

        // R2: run crossing words 11 -> 12 lands in window 2.
        step('0, 1'b1, "R2");
        for (int i = 1; i < 11; i++) step('0, 1'b0, "R2");
        step(10'b0000000111, 1'b0, "R2");
        step(10'b1000000000, 1'b0, "R2");
        close_check(6'b000100, "R2");

        // R3: three-sample runs inside and across words.
        step(10'b1110111011, 1'b1, "R3");
        step(10'b1011101110, 1'b0, "R3");
        step(10'b0000000011, 1'b0, "R3");
        step(10'b1000000000, 1'b0, "R3");
        close_check('0, "R3");

        // R6: hits in windows 0 and 5 accumulate.
        run_interval(30, 2, 27);
        close_check(6'b100001, "R6");

        // R7: flags hold through the next interval despite new hits.
        run_interval(20, 12, -1);
        chk(flags_o == 6'b000000 && strobe_o == 1'b0, "R7", int'(flags_o), 0);
        close_check(6'b000100, "R7");

        // R5: beyond last boundary and beyond saturation.
        run_interval(80, 35, 70);
        close_check('0, "R5");

        // R4: zero-width first window pushes index 0 into window 1.
        set_bounds(0, 10, 15, 20, 25, 30);
        run_interval(4, 0, -1);
        close_check(6'b000010, "R4");
        set_bounds(5, 10, 15, 20, 25, 30);

        // R9: legacy collapse.
        legacy_mode_i = 1'b1;
        run_interval(12, 7, -1);
        close_check(6'b000011, "R9");
        run_interval(14, 12, -1);
        close_check(6'b000010, "R9");
        run_interval(20, 17, -1);
        close_check(6'b000000, "R9");
        run_interval(8, 2, -1);
        close_check(6'b000001, "R9");
        legacy_mode_i = 1'b0;

        // Random intervals, random sorted bounds and mode.
        for (int n = 0; n < 60; n++) begin
            for (int k = 0; k < NB; k++) b[k] = int'($urandom_range(63, 0));
            for (int x = 0; x < NB; x++) begin
                for (int y = 0; y < NB - 1; y++) begin
                    if (b[y] > b[y+1]) begin
                        tmp = b[y]; b[y] = b[y+1]; b[y+1] = tmp;
                    end
                end
            end
            set_bounds(b[0], b[1], b[2], b[3], b[4], b[5]);
            legacy_mode_i = 1'($urandom);
            len = int'($urandom_range(80, 1));
            for (int i = 0; i < len; i++) begin
                w = ($urandom_range(7, 0) == 0) ? WW'($urandom)
                                                 : WW'($urandom & $urandom);
                step(w, i == 0, "R6/R7");
            end
        end
        step('0, 1'b1, "R7");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule